// File: doc/BRIEF.md
# Programmable Interval Timer Channel

A single 16-bit down-counting timer channel. Software programs it through one byte-wide write port. A write flagged as control carries the configuration: binary or four-digit BCD counting, one of six output behaviours, and the byte access scheme. A write flagged as data carries count bytes. The counter runs on the block clock. A `gate` input qualifies or triggers counting, depending on the behaviour selected. The `out` pin gives either a level or a pulse, which can drive an interrupt line or act as a rate or square-wave source.

The count can be read at any time through `rd_data`. A latch command freezes a snapshot while counting continues. Bytes leave in the order the access scheme defines, and each `rd_en` pulse advances to the next byte.

Top module: `pit_channel`

## Requirements
- R1: A control write (`wr_ctrl`=1) decodes its byte as follows. Bit 0 is the format (1 = BCD, 0 = binary). Bits 3:1 are the behaviour code. Bits 5:4 are the access field (00 latch, 01 low byte only, 10 high byte only, 11 low then high). Bits 7:6 are ignored. A non-latch control write stops counting. It drives `out` low for behaviour 0 and high for every other behaviour.
- R2: Behaviour codes 6 and 7 act exactly as codes 2 and 3.
- R3: With access 01, one data byte sets the count to {00,byte}. With access 10, one data byte sets it to {byte,00}. With access 11, the low byte comes first and the high byte second. A control write resets the byte order to "low next". Reads show the byte that the access field and read order select.
- R4: A latch command captures the count value present before that clock edge. `rd_data` shows the captured value and stays unchanged while counting goes on. The latch is released after its last byte is read. A second latch command while a value is held is ignored.
- R5: Behaviour 0: the count is loaded on the edge after the final count byte. It then decrements once per clock. `out` rises on the edge where the count reaches zero. A new count write drives `out` low again.
- R6: Behaviour 0: after zero the count wraps to FFFF (binary) and keeps decrementing, and `out` stays high.
- R7: In behaviours 0 and 4, a low `gate` holds the count. Decrementing resumes when `gate` returns high.
- R8: Behaviour 1: once a count is programmed, a `gate` rising edge loads it and drives `out` low on that edge. A count of N gives a low pulse of N clocks. A new rising edge during the pulse reloads the count and extends the pulse.
- R9: Behaviour 2: the count reloads itself every N clocks. `out` is low for exactly one clock in each period, on the cycle where the count is 1.
- R10: Behaviour 3: the count steps down by two per clock, starting from N with bit 0 cleared. Each time it would reach zero it reloads and `out` toggles, which gives N/2 clocks high and N/2 clocks low for even N.
- R11: Behaviour 4: a count write sets `out` high, and the count loads on the next edge. When the count reaches zero, `out` goes low for exactly one clock, once per programmed count.
- R12: Behaviour 5: a count write sets `out` high. Each `gate` rising edge loads the count. When the count reaches zero, `out` is low for exactly one clock.
- R13: In BCD format each nibble counts down 9..0 and borrows from the next nibble. 0000 wraps to 9999.
- R14: In behaviours 2 and 3, a low `gate` forces `out` high on the next edge and holds the count. A `gate` rising edge restarts the period from the programmed count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one byte |
| wr_ctrl | input | 1 | 1: byte is a control word, 0: byte is a count byte |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Advances the read byte order; releases a latch after its last byte |
| rd_data | output | 8 | Currently selected byte of the latched or live count |
| gate | input | 1 | Gate / trigger input |
| out | output | 1 | Timer output |

## Verification
A latch command can arrive on the same edge as a decrement. The captured value must be the count from before that edge, not the decremented one. The bench issues latch commands at cycle offsets it tracks from the load edge, in fixed cases and in seeded random runs in both binary and BCD. It then reads both bytes and compares them with counts computed by decimal and modulo arithmetic in the bench. A retrigger that lands just before the pulse would end is also driven in behaviour 1, where `out` must stay low through the extended pulse.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int DIGITS = CNT_W / 4;

    localparam logic [CNT_W-1:0] CNT_ONE = 1;
    localparam logic [CNT_W-1:0] CNT_TWO = 2;

    typedef enum logic [2:0] {
        M_TERM     = 3'd0,
        M_ONESHOT  = 3'd1,
        M_RATE     = 3'd2,
        M_SQUARE   = 3'd3,
        M_SWSTROBE = 3'd4,
        M_HWSTROBE = 3'd5
    } pit_mode_e;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_PAIR  = 2'd3
    } acc_e;

    typedef struct packed {
        pit_mode_e mode;
        acc_e      acc;
        logic      bcd;
    } cfg_t;

    // Codes with the middle bit set are the periodic behaviours; top bit is dropped.
    function automatic pit_mode_e decode_mode(input logic [2:0] f);
        if (f[1]) return pit_mode_e'({1'b0, f[1:0]});
        return pit_mode_e'(f);
    endfunction

    function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v, input logic bcd);
        logic [CNT_W-1:0] r;
        logic             borrow;
        r = v - CNT_ONE;
        if (bcd) begin
            r      = v;
            borrow = 1'b1;
            for (int i = 0; i < DIGITS; i++) begin
                if (borrow) begin
                    if (v[i*4 +: 4] == 4'd0) begin
                        r[i*4 +: 4] = 4'd9;
                    end else begin
                        r[i*4 +: 4] = v[i*4 +: 4] - 4'd1;
                        borrow      = 1'b0;
                    end
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/pit_regs.sv
module pit_regs
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_ctrl,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [CNT_W-1:0]  live_count,
    output pit_mode_e         mode_q,
    output logic              bcd_q,
    output pit_mode_e         new_mode,
    output logic              cfg_wr,
    output logic              count_wr,
    output logic [CNT_W-1:0]  reload_q,
    output logic [BYTE_W-1:0] rd_data
);

    cfg_t             cfg_q;
    cfg_t             cfg_new;
    logic             wr_tgl;
    logic             rd_tgl;
    logic             latched;
    logic [CNT_W-1:0] latch_val;
    logic [CNT_W-1:0] rd_src;
    logic             latch_cmd;
    logic             sel_unused;

    assign sel_unused = ^wr_data[7:6];

    always_comb begin
        cfg_new.mode = decode_mode(wr_data[3:1]);
        cfg_new.acc  = acc_e'(wr_data[5:4]);
        cfg_new.bcd  = wr_data[0];
    end

    assign latch_cmd = wr_en && wr_ctrl && (cfg_new.acc == ACC_LATCH);
    assign cfg_wr    = wr_en && wr_ctrl && (cfg_new.acc != ACC_LATCH);
    assign count_wr  = wr_en && !wr_ctrl && ((cfg_q.acc != ACC_PAIR) || wr_tgl);
    assign mode_q    = cfg_q.mode;
    assign bcd_q     = cfg_q.bcd;
    assign new_mode  = cfg_new.mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q     <= '{mode: M_TERM, acc: ACC_PAIR, bcd: 1'b0};
            wr_tgl    <= 1'b0;
            rd_tgl    <= 1'b0;
            latched   <= 1'b0;
            latch_val <= '0;
            reload_q  <= '0;
        end else begin
            if (rd_en) begin
                if ((cfg_q.acc == ACC_PAIR) && !rd_tgl) begin
                    rd_tgl <= 1'b1;
                end else begin
                    rd_tgl  <= 1'b0;
                    latched <= 1'b0;
                end
            end
            if (latch_cmd) begin
                if (!latched) begin
                    latched   <= 1'b1;
                    latch_val <= live_count;
                end
            end else if (cfg_wr) begin
                cfg_q   <= cfg_new;
                wr_tgl  <= 1'b0;
                rd_tgl  <= 1'b0;
                latched <= 1'b0;
            end else if (wr_en) begin
                case (cfg_q.acc)
                    ACC_LO:  reload_q <= {{BYTE_W{1'b0}}, wr_data};
                    ACC_HI:  reload_q <= {wr_data, {BYTE_W{1'b0}}};
                    ACC_PAIR: begin
                        if (!wr_tgl) reload_q[BYTE_W-1:0]     <= wr_data;
                        else         reload_q[CNT_W-1:BYTE_W] <= wr_data;
                        wr_tgl <= !wr_tgl;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rd_src  = latched ? latch_val : live_count;
    assign rd_data = ((cfg_q.acc == ACC_HI) || ((cfg_q.acc == ACC_PAIR) && rd_tgl))
                     ? rd_src[CNT_W-1:BYTE_W] : rd_src[BYTE_W-1:0];

    // R4: a held snapshot does not move while the counter runs
    a_r4_latch_holds: assert property (@(posedge clk) disable iff (rst)
        (latched && !wr_en && !rd_en) |=> $stable(rd_data));

endmodule

// File: rtl/pit_core.sv
module pit_core
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  pit_mode_e        mode,
    input  logic             bcd,
    input  pit_mode_e        new_mode,
    input  logic             cfg_wr,
    input  logic             count_wr,
    input  logic [CNT_W-1:0] reload,
    input  logic             gate,
    output logic [CNT_W-1:0] count_q,
    output logic             out_q
);

    logic gate_q;
    logic armed;
    logic load_pend;
    logic running;
    logic fired;
    logic trig;
    logic [CNT_W-1:0] even_reload;

    assign trig        = gate && !gate_q;
    assign even_reload = reload & ~CNT_ONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q    <= 1'b0;
            armed     <= 1'b0;
            load_pend <= 1'b0;
            running   <= 1'b0;
            fired     <= 1'b0;
            count_q   <= '0;
            out_q     <= 1'b1;
        end else begin
            gate_q <= gate;
            if (cfg_wr) begin
                out_q     <= (new_mode != M_TERM);
                armed     <= 1'b0;
                load_pend <= 1'b0;
                running   <= 1'b0;
            end else if (count_wr) begin
                armed <= 1'b1;
                if (mode == M_TERM) out_q <= 1'b0;
                if (mode == M_SWSTROBE || mode == M_HWSTROBE) out_q <= 1'b1;
                if (mode != M_ONESHOT && mode != M_HWSTROBE) begin
                    load_pend <= 1'b1;
                    running   <= 1'b0;
                end
            end else begin
                case (mode)
                    M_TERM, M_SWSTROBE: begin
                        if (mode == M_SWSTROBE) out_q <= 1'b1;
                        if (load_pend) begin
                            count_q   <= reload;
                            load_pend <= 1'b0;
                            running   <= 1'b1;
                            fired     <= 1'b0;
                        end else if (running && gate) begin
                            count_q <= step_down(count_q, bcd);
                            if (count_q == CNT_ONE) begin
                                if (mode == M_TERM) begin
                                    out_q <= 1'b1;
                                end else if (!fired) begin
                                    out_q <= 1'b0;
                                    fired <= 1'b1;
                                end
                            end
                        end
                    end
                    M_ONESHOT, M_HWSTROBE: begin
                        if (mode == M_HWSTROBE) out_q <= 1'b1;
                        if (trig && armed) begin
                            count_q <= reload;
                            running <= 1'b1;
                            if (mode == M_ONESHOT) out_q <= 1'b0;
                        end else if (running) begin
                            count_q <= step_down(count_q, bcd);
                            if (count_q == CNT_ONE) begin
                                running <= 1'b0;
                                out_q   <= (mode == M_ONESHOT);
                            end
                        end
                    end
                    M_RATE, M_SQUARE: begin
                        if (!gate) begin
                            out_q <= 1'b1;
                        end else if (load_pend || (trig && armed)) begin
                            count_q   <= (mode == M_SQUARE) ? even_reload : reload;
                            load_pend <= 1'b0;
                            out_q     <= 1'b1;
                        end else if (armed) begin
                            if (mode == M_RATE) begin
                                if (count_q == CNT_ONE) begin
                                    count_q <= reload;
                                    out_q   <= 1'b1;
                                end else begin
                                    count_q <= step_down(count_q, bcd);
                                    if (count_q == CNT_TWO) out_q <= 1'b0;
                                end
                            end else begin
                                if (count_q == CNT_TWO) begin
                                    count_q <= even_reload;
                                    out_q   <= !out_q;
                                end else begin
                                    count_q <= step_down(step_down(count_q, bcd), bcd);
                                end
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R7: gate low freezes the count in the gated one-shot behaviours
    a_r7_gate_pause: assert property (@(posedge clk) disable iff (rst)
        ((mode == M_TERM || mode == M_SWSTROBE) && !gate && !load_pend && !cfg_wr && !count_wr)
        |=> $stable(count_q));

    // R6: once high in behaviour 0, out stays high until reprogrammed
    a_r6_term_stays_high: assert property (@(posedge clk) disable iff (rst)
        (mode == M_TERM && out_q && !cfg_wr && !count_wr) |=> out_q);

    // R11 / R12: strobe pulses last a single clock
    a_r11_strobe_single: assert property (@(posedge clk) disable iff (rst)
        ((mode == M_SWSTROBE || mode == M_HWSTROBE) && !out_q && !cfg_wr) |=> out_q);

    // R9: the rate pulse is one clock wide
    a_r9_rate_low_one: assert property (@(posedge clk) disable iff (rst)
        (mode == M_RATE && gate && !out_q && !cfg_wr && !count_wr) |=> out_q);

    // R14: gate low in the periodic behaviours forces out high
    a_r14_gate_forces_high: assert property (@(posedge clk) disable iff (rst)
        ((mode == M_RATE || mode == M_SQUARE) && !gate && !cfg_wr) |=> out_q);

endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_ctrl,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              gate,
    output logic              out
);

    pit_mode_e        mode_q;
    pit_mode_e        new_mode;
    logic             bcd_q;
    logic             cfg_wr;
    logic             count_wr;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] count_q;

    pit_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_ctrl    (wr_ctrl),
        .wr_data    (wr_data),
        .rd_en      (rd_en),
        .live_count (count_q),
        .mode_q     (mode_q),
        .bcd_q      (bcd_q),
        .new_mode   (new_mode),
        .cfg_wr     (cfg_wr),
        .count_wr   (count_wr),
        .reload_q   (reload_q),
        .rd_data    (rd_data)
    );

    pit_core u_core (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode_q),
        .bcd      (bcd_q),
        .new_mode (new_mode),
        .cfg_wr   (cfg_wr),
        .count_wr (count_wr),
        .reload   (reload_q),
        .gate     (gate),
        .count_q  (count_q),
        .out_q    (out)
    );

endmodule

// File: tb/sim_pit_channel.sv
module sim_pit_channel;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic       clk;
    logic       rst;
    logic       wr_en;
    logic       wr_ctrl;
    logic [7:0] wr_data;
    logic       rd_en;
    logic [7:0] rd_data;
    logic       gate;
    logic       out;

    int checks = 0;
    int fails  = 0;

    pit_channel u0 (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_ctrl (wr_ctrl),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .gate    (gate),
        .out     (out)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic write_ctrl(input logic [7:0] b);
        wr_en = 1'b1; wr_ctrl = 1'b1; wr_data = b;
        step(1);
        wr_en = 1'b0; wr_ctrl = 1'b0;
    endtask

    task automatic write_cnt(input logic [7:0] b);
        wr_en = 1'b1; wr_ctrl = 1'b0; wr_data = b;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic read_pulse();
        rd_en = 1'b1;
        step(1);
        rd_en = 1'b0;
    endtask

    function automatic int bcd_to_int(input logic [15:0] v);
        return v[15:12]*1000 + v[11:8]*100 + v[7:4]*10 + v[3:0];
    endfunction

    function automatic logic [15:0] int_to_bcd(input int d);
        logic [15:0] r;
        r[3:0]   = 4'(d % 10);
        r[7:4]   = 4'((d / 10) % 10);
        r[11:8]  = 4'((d / 100) % 10);
        r[15:12] = 4'((d / 1000) % 10);
        return r;
    endfunction

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        report();
        $finish;
    end

    initial begin : main
        rst = 1'b1; wr_en = 1'b0; wr_ctrl = 1'b0; wr_data = 8'h00; rd_en = 1'b0; gate = 1'b1;
        void'($urandom(32'd20240611));
        step(3);
        rst = 1'b0;
        chk("R1 reset out", int'(out), 1);
        chk("R1 reset rd_data", int'(rd_data), 0);

        // R1 R5: behaviour 0, binary, access pair, count 5
        write_ctrl(8'h30);
        chk("R5 out low after control", int'(out), 0);
        write_cnt(8'h05); write_cnt(8'h00);
        step(1);
        chk("R5 load edge count", int'(rd_data), 5);
        step(4);
        chk("R5 out low at count 1", int'(out), 0);
        step(1);
        chk("R5 out high at zero", int'(out), 1);
        chk("R5 count zero", int'(rd_data), 0);
        step(1);
        chk("R6 wrap low byte", int'(rd_data), 8'hFF);
        chk("R6 out stays high", int'(out), 1);
        step(7);
        chk("R6 out still high", int'(out), 1);

        // R7: gate pause
        write_ctrl(8'h30);
        write_cnt(8'h0A); write_cnt(8'h00);
        step(4);
        chk("R7 count before pause", int'(rd_data), 7);
        gate = 1'b0;
        step(5);
        chk("R7 count held", int'(rd_data), 7);
        chk("R7 out low while held", int'(out), 0);
        gate = 1'b1;
        step(2);
        chk("R7 count resumes", int'(rd_data), 5);

        // R4: latch on a decrement edge
        write_ctrl(8'h30);
        write_cnt(8'h23); write_cnt(8'h01);
        step(1);
        step(3);
        chk("R4 live before latch", int'(rd_data), 8'h20);
        write_ctrl(8'h00);
        chk("R4 latched low byte", int'(rd_data), 8'h20);
        write_ctrl(8'h00);
        step(3);
        chk("R4 second latch ignored, value held", int'(rd_data), 8'h20);
        read_pulse();
        chk("R4 latched high byte", int'(rd_data), 8'h01);
        read_pulse();
        chk("R4 released to live", int'(rd_data), 8'h19);

        // R3: access schemes and order reset
        write_ctrl(8'h10);
        write_cnt(8'h07);
        step(1);
        chk("R3 low-only load", int'(rd_data), 7);
        write_ctrl(8'h20);
        write_cnt(8'h02);
        step(1);
        chk("R3 high-only load", int'(rd_data), 8'h02);
        step(1);
        chk("R3 high-only decrement", int'(rd_data), 8'h01);
        write_ctrl(8'h30);
        write_cnt(8'h55);
        write_ctrl(8'h30);
        write_cnt(8'h05); write_cnt(8'h00);
        step(1);
        chk("R3 order reset by control", int'(rd_data), 5);
        read_pulse();
        chk("R3 high byte after one read", int'(rd_data), 0);

        // R13: BCD borrow and wrap
        write_ctrl(8'h31);
        write_cnt(8'h02); write_cnt(8'h01);
        step(1);
        step(3);
        chk("R13 BCD borrow 0100->0099", int'(rd_data), 8'h99);
        write_ctrl(8'h31);
        write_cnt(8'h01); write_cnt(8'h00);
        step(1);
        step(1);
        chk("R13 BCD zero reached", int'(out), 1);
        step(1);
        write_ctrl(8'h00);
        chk("R13 BCD wrap low", int'(rd_data), 8'h99);
        read_pulse();
        chk("R13 BCD wrap high", int'(rd_data), 8'h99);
        read_pulse();

        // R13 R4 R6: seeded random countdowns, binary and BCD
        for (int it = 0; it < 16; it++) begin
            logic        use_bcd;
            logic [15:0] v;
            logic [15:0] e;
            int          k;
            use_bcd = it[0];
            k = $urandom_range(0, 40);
            if (use_bcd) begin
                v = int_to_bcd($urandom_range(0, 9999));
                e = int_to_bcd((bcd_to_int(v) - k + 10000) % 10000);
            end else begin
                v = 16'($urandom);
                e = v - 16'(k);
            end
            write_ctrl(use_bcd ? 8'h31 : 8'h30);
            write_cnt(v[7:0]); write_cnt(v[15:8]);
            step(1);
            step(k);
            write_ctrl(8'h00);
            chk(use_bcd ? "R13 random BCD low" : "R4 random binary low", int'(rd_data), int'(e[7:0]));
            read_pulse();
            chk(use_bcd ? "R13 random BCD high" : "R4 random binary high", int'(rd_data), int'(e[15:8]));
            read_pulse();
        end

        // R9 R14: behaviour 2, count 4
        gate = 1'b1;
        write_ctrl(8'h34);
        write_cnt(8'h04); write_cnt(8'h00);
        step(1);
        chk("R9 high after load", int'(out), 1);
        step(2);
        chk("R9 high before pulse", int'(out), 1);
        step(1);
        chk("R9 one-clock low", int'(out), 0);
        step(1);
        chk("R9 high after pulse", int'(out), 1);
        step(2);
        chk("R9 high second period", int'(out), 1);
        step(1);
        chk("R9 low second period", int'(out), 0);
        gate = 1'b0;
        step(1);
        chk("R14 gate low forces high", int'(out), 1);
        step(3);
        chk("R14 stays high while gate low", int'(out), 1);
        gate = 1'b1;
        step(1);
        step(2);
        chk("R14 restart high", int'(out), 1);
        step(1);
        chk("R14 restart full period", int'(out), 0);

        // R10 R2: behaviour code 7 acts as square wave, count 6
        write_ctrl(8'h3E);
        write_cnt(8'h06); write_cnt(8'h00);
        step(1);
        chk("R2 alias square high after load", int'(out), 1);
        step(2);
        chk("R10 high half", int'(out), 1);
        step(1);
        chk("R10 toggles low", int'(out), 0);
        step(2);
        chk("R10 low half", int'(out), 0);
        step(1);
        chk("R10 toggles high", int'(out), 1);

        // R11: behaviour 4, count 3
        write_ctrl(8'h38);
        chk("R11 out high after control", int'(out), 1);
        write_cnt(8'h03); write_cnt(8'h00);
        step(3);
        chk("R11 high before strobe", int'(out), 1);
        step(1);
        chk("R11 strobe low", int'(out), 0);
        step(1);
        chk("R11 strobe one clock", int'(out), 1);
        step(6);
        chk("R11 single strobe", int'(out), 1);

        // R8: behaviour 1, count 4, with retrigger
        gate = 1'b0;
        write_ctrl(8'h32);
        write_cnt(8'h04); write_cnt(8'h00);
        chk("R8 idle high", int'(out), 1);
        step(2);
        chk("R8 no trigger stays high", int'(out), 1);
        gate = 1'b1;
        step(1);
        chk("R8 trigger low", int'(out), 0);
        step(3);
        chk("R8 low through pulse", int'(out), 0);
        step(1);
        chk("R8 pulse N clocks", int'(out), 1);
        gate = 1'b0;
        step(1);
        gate = 1'b1;
        step(1);
        chk("R8 second trigger", int'(out), 0);
        gate = 1'b0;
        step(2);
        gate = 1'b1;
        step(1);
        step(1);
        chk("R8 retrigger extends", int'(out), 0);
        step(2);
        chk("R8 still low", int'(out), 0);
        step(1);
        chk("R8 extended pulse ends", int'(out), 1);

        // R12: behaviour 5, count 3
        gate = 1'b0;
        write_ctrl(8'h3A);
        write_cnt(8'h03); write_cnt(8'h00);
        chk("R12 high after count", int'(out), 1);
        step(2);
        gate = 1'b1;
        step(1);
        step(2);
        chk("R12 high during count", int'(out), 1);
        step(1);
        chk("R12 strobe low", int'(out), 0);
        step(1);
        chk("R12 strobe one clock", int'(out), 1);
        gate = 1'b0;
        step(1);
        gate = 1'b1;
        step(1);
        step(2);
        chk("R12 rearm high", int'(out), 1);
        step(1);
        chk("R12 rearm strobe", int'(out), 0);
        step(1);
        chk("R12 rearm strobe ends", int'(out), 1);

        report();
        $finish;
    end

endmodule